// File: doc/BRIEF.md
# Push-Button Wake and Reset Controller

This block watches an active-low push-button and times each press with a slow tick. The tick comes in as a clock enable. A press held past the first wake time lifts the system out of ship mode when it is released. In the running state the same press time raises a short-press event. Holding past a longer, selectable threshold raises a long-press event and arms one configured action, which is carried out when the button is released. The action is one of: hardware reset pulse, power cycle, autowake, return to ship mode, or nothing. The host can cancel an armed action by writing an abort strobe while the button is still held.

The block also drives the power-up order of two rails. The system rail comes on first. The LDO rail follows a fixed number of ticks later. For a power cycle or an autowake, both rails are held off for a delay before the power-up order runs again. A separate bus-silence watchdog issues a hardware reset pulse if no host transaction arrives within a set window after input power is detected. The watchdog fires once and stays disarmed until the host enables it again. All durations are parameters counted in ticks. The defaults assume a 1 ms tick.

Top module: `pbtn_pwr_ctrl`

## Requirements
- R1: After reset, `ship_req` is 1, both rails are off, and no pulse output is active.
- R2: In ship mode, the block starts power-up when either of two things happens. One is `vin_ok` being high. The other is the release of a press that lasted at least the wake threshold: W1_SHORT_T ticks when `cfg_wake1_sel`=0, or W1_LONG_T ticks when it is 1. A shorter press leaves the block in ship mode.
- R3: Power-up turns on `sys_rail_en` first. `ldo_rail_en` turns on LDO_DLY_T ticks later. The LDO rail is never on without the system rail.
- R4: While running, a press that reaches the wake threshold gives exactly one `evt_short` pulse. A press that reaches the long threshold gives exactly one `evt_long` pulse. The long threshold is LONG_A_T ticks when `cfg_long_sel`=0, or LONG_B_T ticks when it is 1. A press one tick short of a threshold gives no pulse for that threshold.
- R5: On release of a press that reached the long threshold, the block acts on `cfg_long_act`: 0 does nothing, 1 issues a hardware reset, 2 runs a power cycle, 3 runs an autowake, 4 enters ship mode, and 5 to 7 do nothing.
- R6: A hardware reset is a one-cycle `rst_pulse`, and the rails stay on. When `cfg_rst_need_vin`=1, the reset is issued only if `vin_ok` is high at release. Otherwise nothing happens.
- R7: A hardware reset requested while `lp_n` is low is carried out as a power cycle, and no `rst_pulse` is issued.
- R8: A power cycle holds both rails off for CYCLE_OFF_T ticks and then runs the R3 sequence.
- R9: An autowake holds both rails off for a delay chosen by `cfg_restart_sel`: 00 gives RESTART_T0, 01 gives RESTART_T1, 10 gives RESTART_T2, and 11 gives RESTART_T3. It then runs the R3 sequence.
- R10: A `host_abort` strobe while the button is held cancels the pending action for that press, whether it comes before or after the long threshold. The `evt_long` event is still reported.
- R11: The watchdog is armed by a rising edge of `cfg_wd_en`, including the edge when the block leaves reset with `cfg_wd_en` high. Once armed, a rise of `vin_ok` opens a window of WD_T ticks. If that window ends with no `host_txn`, the block issues one `rst_pulse` and disarms. A `host_txn` inside the window closes it and also disarms the watchdog. Only a fresh rising edge of `cfg_wd_en` arms it again.
- R12: No press timer, rail delay or watchdog window advances in a cycle where `tick_en` is low.
- R13: `btn_n` is active low and passes through a two-flop synchroniser. A press seen by H clock edges with one tick per cycle counts as H ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Slow timebase enable, one pulse per tick |
| btn_n | input | 1 | Deglitched push-button, low while pressed |
| vin_ok | input | 1 | Input supply valid |
| lp_n | input | 1 | Low-power pin, low means low-power state |
| host_txn | input | 1 | Strobe for each host bus transaction |
| host_abort | input | 1 | Host write that cancels the pending long-press action |
| cfg_wake1_sel | input | 1 | Wake threshold select |
| cfg_long_sel | input | 1 | Long-press threshold select |
| cfg_long_act | input | 3 | Long-press action code |
| cfg_restart_sel | input | 2 | Autowake restart delay select |
| cfg_rst_need_vin | input | 1 | Allow hardware reset only with valid input |
| cfg_wd_en | input | 1 | Bus-silence watchdog enable |
| rst_pulse | output | 1 | One-cycle hardware reset pulse |
| sys_rail_en | output | 1 | System rail enable |
| ldo_rail_en | output | 1 | LDO rail enable |
| ship_req | output | 1 | Ship mode request |
| evt_short | output | 1 | Short-press event pulse |
| evt_long | output | 1 | Long-press event pulse |

## Verification
The bench builds the block with these parameter values: wake thresholds of 4 and 8 ticks, long thresholds of 12 and 20, an LDO delay of 5, a power-cycle off time of 6, restart delays of 3, 6, 12 and 25, and a watchdog window of 40. The tick is held high, so one tick equals one clock cycle. With these values, every press length at and one below each threshold can be tried. Every action code and every restart setting can be swept. Every rail-off and power-up interval can be timed to the exact cycle. Several complete watchdog arm, fire and disarm rounds also fit, all within a few thousand cycles.

// File: rtl/pbtn_pkg.sv
package pbtn_pkg;

  typedef enum logic [1:0] {
    ST_SHIP    = 2'd0,
    ST_PWRUP   = 2'd1,
    ST_ON      = 2'd2,
    ST_OFFWAIT = 2'd3
  } pbtn_state_e;

  localparam logic [2:0] ACT_NONE  = 3'd0;
  localparam logic [2:0] ACT_HWRST = 3'd1;
  localparam logic [2:0] ACT_PCYC  = 3'd2;
  localparam logic [2:0] ACT_AUTO  = 3'd3;
  localparam logic [2:0] ACT_SHIP  = 3'd4;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pbtn_press_timer.sv
module pbtn_press_timer
  import pbtn_pkg::*;
#(
  parameter int W1_SHORT_T = 125,
  parameter int W1_LONG_T  = 500,
  parameter int LONG_A_T   = 5000,
  parameter int LONG_B_T   = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic btn_n,
  input  logic cfg_wake1_sel,
  input  logic cfg_long_sel,
  output logic pressed,
  output logic released,
  output logic hit_wake1,
  output logic hit_long,
  output logic held_wake1
);

  localparam int CNT_MAX = max2(max2(LONG_A_T, LONG_B_T), W1_LONG_T);
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] W1S_C  = CW'(W1_SHORT_T);
  localparam logic [CW-1:0] W1L_C  = CW'(W1_LONG_T);
  localparam logic [CW-1:0] LGA_C  = CW'(LONG_A_T);
  localparam logic [CW-1:0] LGB_C  = CW'(LONG_B_T);
  localparam logic [CW-1:0] SAT_C  = CW'(CNT_MAX);

  logic          sync1_q, sync2_q, prs_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] w1_lim, lg_lim;

  assign w1_lim = cfg_wake1_sel ? W1L_C : W1S_C;
  assign lg_lim = cfg_long_sel  ? LGB_C : LGA_C;

  assign pressed    = ~sync2_q;
  assign released   = prs_q & ~pressed;
  assign hit_wake1  = pressed & tick_en & (cnt_q == w1_lim - 1'b1);
  assign hit_long   = pressed & tick_en & (cnt_q == lg_lim - 1'b1);
  assign held_wake1 = (cnt_q >= w1_lim);

  always_comb begin
    cnt_n = cnt_q;
    if (!pressed) begin
      cnt_n = '0;
    end else if (tick_en && (cnt_q != SAT_C)) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      prs_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sync1_q <= btn_n;
      sync2_q <= sync1_q;
      prs_q   <= pressed;
      cnt_q   <= cnt_n;
    end
  end

endmodule

// File: rtl/pbtn_bus_wd.sv
module pbtn_bus_wd #(
  parameter int WD_T = 14000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic vin_ok,
  input  logic host_txn,
  input  logic cfg_wd_en,
  output logic wd_fire
);

  localparam int CW = $clog2(WD_T + 1);
  localparam logic [CW-1:0] LIM_C = CW'(WD_T - 1);

  logic          en_q, vin_q, armed_q, run_q;
  logic          armed_n, run_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          close_win;

  assign wd_fire   = run_q & tick_en & cfg_wd_en & ~host_txn & (cnt_q == LIM_C);
  assign close_win = wd_fire | (run_q & host_txn);

  always_comb begin
    armed_n = armed_q;
    if (!cfg_wd_en) begin
      armed_n = 1'b0;
    end else if (!en_q) begin
      armed_n = 1'b1;
    end else if (close_win) begin
      armed_n = 1'b0;
    end

    run_n = run_q;
    if (!vin_ok || !cfg_wd_en || close_win) begin
      run_n = 1'b0;
    end else if (!vin_q && armed_q) begin
      run_n = 1'b1;
    end

    cnt_n = cnt_q;
    if (!run_q) begin
      cnt_n = '0;
    end else if (tick_en) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      vin_q   <= 1'b0;
      armed_q <= 1'b0;
      run_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      en_q    <= cfg_wd_en;
      vin_q   <= vin_ok;
      armed_q <= armed_n;
      run_q   <= run_n;
      cnt_q   <= cnt_n;
    end
  end

endmodule

// File: rtl/pbtn_rail_seq.sv
module pbtn_rail_seq
  import pbtn_pkg::*;
#(
  parameter int LDO_DLY_T   = 20,
  parameter int CYCLE_OFF_T = 600,
  parameter int RESTART_T0  = 600,
  parameter int RESTART_T1  = 1200,
  parameter int RESTART_T2  = 2400,
  parameter int RESTART_T3  = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       pressed,
  input  logic       released,
  input  logic       hit_wake1,
  input  logic       hit_long,
  input  logic       held_wake1,
  input  logic       vin_ok,
  input  logic       lp_n,
  input  logic       host_abort,
  input  logic [2:0] cfg_long_act,
  input  logic [1:0] cfg_restart_sel,
  input  logic       cfg_rst_need_vin,
  input  logic       wd_fire,
  output logic       rst_pulse,
  output logic       sys_rail_en,
  output logic       ldo_rail_en,
  output logic       ship_req,
  output logic       evt_short,
  output logic       evt_long
);

  localparam int DMAX = max2(max2(LDO_DLY_T, CYCLE_OFF_T),
                             max2(max2(RESTART_T0, RESTART_T1), max2(RESTART_T2, RESTART_T3)));
  localparam int DW = $clog2(DMAX + 1);
  localparam logic [DW-1:0] LDO_C = DW'(LDO_DLY_T);
  localparam logic [DW-1:0] CYC_C = DW'(CYCLE_OFF_T);
  localparam logic [DW-1:0] RD0_C = DW'(RESTART_T0);
  localparam logic [DW-1:0] RD1_C = DW'(RESTART_T1);
  localparam logic [DW-1:0] RD2_C = DW'(RESTART_T2);
  localparam logic [DW-1:0] RD3_C = DW'(RESTART_T3);

  pbtn_state_e   state_q, state_n;
  logic [DW-1:0] dly_q, dly_n, tgt_q, tgt_n, rs_t;
  logic          pend_q, pend_n, abort_q, abort_n;
  logic          btn_rst;
  logic          rst_q, evs_q, evl_q;
  logic          is_on;

  assign is_on = (state_q == ST_ON);

  always_comb begin
    case (cfg_restart_sel)
      2'd0:    rs_t = RD0_C;
      2'd1:    rs_t = RD1_C;
      2'd2:    rs_t = RD2_C;
      default: rs_t = RD3_C;
    endcase
  end

  always_comb begin
    state_n = state_q;
    dly_n   = dly_q;
    tgt_n   = tgt_q;
    pend_n  = pend_q;
    abort_n = abort_q;
    btn_rst = 1'b0;

    if (released) begin
      pend_n  = 1'b0;
      abort_n = 1'b0;
    end else if (pressed && host_abort) begin
      pend_n  = 1'b0;
      abort_n = 1'b1;
    end else if (is_on && hit_long && !abort_q) begin
      pend_n  = 1'b1;
    end

    case (state_q)
      ST_SHIP: begin
        if (vin_ok || (released && held_wake1)) begin
          state_n = ST_PWRUP;
          dly_n   = '0;
        end
      end
      ST_PWRUP: begin
        if (tick_en) begin
          if (dly_q == LDO_C - 1'b1) begin
            state_n = ST_ON;
            dly_n   = '0;
          end else begin
            dly_n = dly_q + 1'b1;
          end
        end
      end
      ST_ON: begin
        if (released && pend_q) begin
          case (cfg_long_act)
            ACT_HWRST: begin
              if (!(cfg_rst_need_vin && !vin_ok)) begin
                if (!lp_n) begin
                  state_n = ST_OFFWAIT;
                  dly_n   = '0;
                  tgt_n   = CYC_C;
                end else begin
                  btn_rst = 1'b1;
                end
              end
            end
            ACT_PCYC: begin
              state_n = ST_OFFWAIT;
              dly_n   = '0;
              tgt_n   = CYC_C;
            end
            ACT_AUTO: begin
              state_n = ST_OFFWAIT;
              dly_n   = '0;
              tgt_n   = rs_t;
            end
            ACT_SHIP: begin
              state_n = ST_SHIP;
            end
            default: ;
          endcase
        end
      end
      ST_OFFWAIT: begin
        if (tick_en) begin
          if (dly_q == tgt_q - 1'b1) begin
            state_n = ST_PWRUP;
            dly_n   = '0;
          end else begin
            dly_n = dly_q + 1'b1;
          end
        end
      end
      default: state_n = ST_SHIP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SHIP;
      dly_q   <= '0;
      tgt_q   <= '0;
      pend_q  <= 1'b0;
      abort_q <= 1'b0;
      rst_q   <= 1'b0;
      evs_q   <= 1'b0;
      evl_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      dly_q   <= dly_n;
      tgt_q   <= tgt_n;
      pend_q  <= pend_n;
      abort_q <= abort_n;
      rst_q   <= btn_rst | wd_fire;
      evs_q   <= is_on & hit_wake1;
      evl_q   <= is_on & hit_long;
    end
  end

  assign rst_pulse   = rst_q;
  assign sys_rail_en = (state_q == ST_PWRUP) || (state_q == ST_ON);
  assign ldo_rail_en = (state_q == ST_ON);
  assign ship_req    = (state_q == ST_SHIP);
  assign evt_short   = evs_q;
  assign evt_long    = evl_q;

endmodule

// File: rtl/pbtn_pwr_ctrl.sv
module pbtn_pwr_ctrl #(
  parameter int W1_SHORT_T  = 125,
  parameter int W1_LONG_T   = 500,
  parameter int LONG_A_T    = 5000,
  parameter int LONG_B_T    = 10000,
  parameter int LDO_DLY_T   = 20,
  parameter int CYCLE_OFF_T = 600,
  parameter int RESTART_T0  = 600,
  parameter int RESTART_T1  = 1200,
  parameter int RESTART_T2  = 2400,
  parameter int RESTART_T3  = 5000,
  parameter int WD_T        = 14000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       btn_n,
  input  logic       vin_ok,
  input  logic       lp_n,
  input  logic       host_txn,
  input  logic       host_abort,
  input  logic       cfg_wake1_sel,
  input  logic       cfg_long_sel,
  input  logic [2:0] cfg_long_act,
  input  logic [1:0] cfg_restart_sel,
  input  logic       cfg_rst_need_vin,
  input  logic       cfg_wd_en,
  output logic       rst_pulse,
  output logic       sys_rail_en,
  output logic       ldo_rail_en,
  output logic       ship_req,
  output logic       evt_short,
  output logic       evt_long
);

  logic pressed, released, hit_wake1, hit_long, held_wake1, wd_fire;

  pbtn_press_timer #(
    .W1_SHORT_T (W1_SHORT_T),
    .W1_LONG_T  (W1_LONG_T),
    .LONG_A_T   (LONG_A_T),
    .LONG_B_T   (LONG_B_T)
  ) u_press (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_en       (tick_en),
    .btn_n         (btn_n),
    .cfg_wake1_sel (cfg_wake1_sel),
    .cfg_long_sel  (cfg_long_sel),
    .pressed       (pressed),
    .released      (released),
    .hit_wake1     (hit_wake1),
    .hit_long      (hit_long),
    .held_wake1    (held_wake1)
  );

  pbtn_bus_wd #(
    .WD_T (WD_T)
  ) u_wd (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .vin_ok    (vin_ok),
    .host_txn  (host_txn),
    .cfg_wd_en (cfg_wd_en),
    .wd_fire   (wd_fire)
  );

  pbtn_rail_seq #(
    .LDO_DLY_T   (LDO_DLY_T),
    .CYCLE_OFF_T (CYCLE_OFF_T),
    .RESTART_T0  (RESTART_T0),
    .RESTART_T1  (RESTART_T1),
    .RESTART_T2  (RESTART_T2),
    .RESTART_T3  (RESTART_T3)
  ) u_seq (
    .clk              (clk),
    .rst_n            (rst_n),
    .tick_en          (tick_en),
    .pressed          (pressed),
    .released         (released),
    .hit_wake1        (hit_wake1),
    .hit_long         (hit_long),
    .held_wake1       (held_wake1),
    .vin_ok           (vin_ok),
    .lp_n             (lp_n),
    .host_abort       (host_abort),
    .cfg_long_act     (cfg_long_act),
    .cfg_restart_sel  (cfg_restart_sel),
    .cfg_rst_need_vin (cfg_rst_need_vin),
    .wd_fire          (wd_fire),
    .rst_pulse        (rst_pulse),
    .sys_rail_en      (sys_rail_en),
    .ldo_rail_en      (ldo_rail_en),
    .ship_req         (ship_req),
    .evt_short        (evt_short),
    .evt_long         (evt_long)
  );

endmodule

// File: rtl/pbtn_pwr_ctrl_chk.sv
module pbtn_pwr_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic sys_rail_en,
  input logic ldo_rail_en,
  input logic ship_req,
  input logic evt_short,
  input logic evt_long
);

  p_ldo_under_sys_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ldo_rail_en |-> sys_rail_en);

  p_ldo_after_sys_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ldo_rail_en) |-> $past(sys_rail_en));

  p_ship_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ship_req |-> (!sys_rail_en && !ldo_rail_en));

  p_ship_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ship_req) |-> (sys_rail_en && !ldo_rail_en));

  p_sys_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rail_en) |-> $past(ldo_rail_en));

  p_evt_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_short && evt_long));

endmodule

bind pbtn_pwr_ctrl pbtn_pwr_ctrl_chk u_chk (.*);

// File: tb/pbtn_pwr_ctrl_tb.sv
module pbtn_pwr_ctrl_tb;

  localparam int W1S = 4, W1L = 8, LGA = 12, LGB = 20, LDO = 5, CYC = 6, WD = 40;
  localparam int RD0 = 3, RD1 = 6, RD2 = 12, RD3 = 25;

  logic clk = 1'b0;
  logic rst_n;
  logic tick_en, btn_n, vin_ok, lp_n, host_txn, host_abort;
  logic cfg_wake1_sel, cfg_long_sel, cfg_rst_need_vin, cfg_wd_en;
  logic [2:0] cfg_long_act;
  logic [1:0] cfg_restart_sel;
  logic rst_pulse, sys_rail_en, ldo_rail_en, ship_req, evt_short, evt_long;

  int n_chk = 0, n_bad = 0;
  int n_short = 0, n_long = 0, n_rst = 0, n_sysfall = 0;
  logic sys_prev = 1'b0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  pbtn_pwr_ctrl #(
    .W1_SHORT_T(W1S), .W1_LONG_T(W1L), .LONG_A_T(LGA), .LONG_B_T(LGB),
    .LDO_DLY_T(LDO), .CYCLE_OFF_T(CYC),
    .RESTART_T0(RD0), .RESTART_T1(RD1), .RESTART_T2(RD2), .RESTART_T3(RD3),
    .WD_T(WD)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .btn_n(btn_n), .vin_ok(vin_ok),
    .lp_n(lp_n), .host_txn(host_txn), .host_abort(host_abort),
    .cfg_wake1_sel(cfg_wake1_sel), .cfg_long_sel(cfg_long_sel),
    .cfg_long_act(cfg_long_act), .cfg_restart_sel(cfg_restart_sel),
    .cfg_rst_need_vin(cfg_rst_need_vin), .cfg_wd_en(cfg_wd_en),
    .rst_pulse(rst_pulse), .sys_rail_en(sys_rail_en), .ldo_rail_en(ldo_rail_en),
    .ship_req(ship_req), .evt_short(evt_short), .evt_long(evt_long)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (evt_short) n_short++;
      if (evt_long)  n_long++;
      if (rst_pulse) n_rst++;
      if (sys_prev && !sys_rail_en) n_sysfall++;
      sys_prev = sys_rail_en;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic press(input int h);
    @(posedge clk); #1 btn_n = 1'b0;
    repeat (h) @(posedge clk);
    #1 btn_n = 1'b1;
  endtask

  task automatic press_abort(input int h, input int a);
    @(posedge clk); #1 btn_n = 1'b0;
    repeat (a) @(posedge clk);
    #1 host_abort = 1'b1;
    @(posedge clk); #1 host_abort = 1'b0;
    repeat (h - a - 1) @(posedge clk);
    #1 btn_n = 1'b1;
  endtask

  task automatic settle();
    repeat (10) @(posedge clk);
  endtask

  // Times the next rails-off stretch and the following power-up stretch.
  task automatic meas(output int off, output int up);
    int g;
    off = 0; up = 0; g = 0;
    @(negedge clk);
    while (sys_rail_en && g < 40) begin @(negedge clk); g++; end
    while (!sys_rail_en && off < 200) begin off++; @(negedge clk); end
    while (sys_rail_en && !ldo_rail_en && up < 200) begin up++; @(negedge clk); end
  endtask

  task automatic wd_wait(output int k);
    k = 0;
    @(posedge clk); #1 vin_ok = 1'b1;
    while (k < 300) begin
      @(negedge clk); k++;
      if (rst_pulse) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL timeout (R1-all) actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int off, up, r0, s0, l0, f0, k;
    int rd[4];
    rd[0] = RD0; rd[1] = RD1; rd[2] = RD2; rd[3] = RD3;
    rst_n = 1'b0; tick_en = 1'b1; btn_n = 1'b1; vin_ok = 1'b0; lp_n = 1'b1;
    host_txn = 1'b0; host_abort = 1'b0; cfg_wake1_sel = 1'b0; cfg_long_sel = 1'b0;
    cfg_long_act = 3'd0; cfg_restart_sel = 2'd1; cfg_rst_need_vin = 1'b0; cfg_wd_en = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ship_req", int'(ship_req), 1);
    check("R1 rails", int'({sys_rail_en, ldo_rail_en}), 0);
    check("R1 pulses", int'({rst_pulse, evt_short, evt_long}), 0);

    // R2 / R13 wake from ship with both wake thresholds
    for (int s = 0; s < 2; s++) begin
      int w1;
      cfg_wake1_sel = 1'(s);
      w1 = (s == 1) ? W1L : W1S;
      press(w1 - 1); settle();
      check("R2/R13 press one short of wake keeps ship", int'(ship_req), 1);
      press(w1); meas(off, up);
      check("R3 ldo delay after wake press", up, LDO);
      check("R3 ldo on after sequence", int'(ldo_rail_en), 1);
      check("R2 left ship on wake press", int'(ship_req), 0);
      cfg_long_act = 3'd4;
      press(LGA); settle();
      check("R5 act 4 enters ship", int'(ship_req), 1);
      check("R5 act 4 rails off", int'(sys_rail_en), 0);
      cfg_long_act = 3'd0;
    end
    cfg_wake1_sel = 1'b0;

    // R2 wake by input power
    @(posedge clk); #1 vin_ok = 1'b1;
    meas(off, up);
    check("R2/R3 vin wake ldo delay", up, LDO);
    check("R2 vin wake running", int'(ldo_rail_en), 1);
    @(posedge clk); #1 vin_ok = 1'b0;
    settle();

    // R4 event thresholds, action none
    s0 = n_short;
    press(W1S - 1); settle();
    check("R4 no short event below wake", n_short - s0, 0);
    for (int ls = 0; ls < 2; ls++) begin
      int t;
      cfg_long_sel = 1'(ls);
      t = (ls == 1) ? LGB : LGA;
      for (int d = -1; d <= 0; d++) begin
        s0 = n_short; l0 = n_long; f0 = n_sysfall;
        press(t + d); settle();
        check("R4 short event count", n_short - s0, 1);
        check("R4 long event at threshold", n_long - l0, (d == 0) ? 1 : 0);
        check("R5 act 0 keeps rails", n_sysfall - f0, 0);
      end
    end
    cfg_long_sel = 1'b0;

    // R5 sweep of action codes
    for (int a = 0; a < 8; a++) begin
      cfg_long_act = 3'(a);
      r0 = n_rst; f0 = n_sysfall;
      if (a == 2) begin
        press(LGA); meas(off, up);
        check("R8 power cycle off time", off, CYC);
        check("R8 power cycle ldo delay", up, LDO);
      end else if (a == 3) begin
        for (int rs = 0; rs < 4; rs++) begin
          cfg_restart_sel = 2'(rs);
          press(LGA); meas(off, up);
          check("R9 autowake restart delay", off, rd[rs]);
          check("R9 autowake ldo delay", up, LDO);
        end
      end else if (a == 4) begin
        press(LGA); settle();
        check("R5 act 4 ship", int'(ship_req), 1);
        press(W1S); meas(off, up);
        check("R2 rewake after act 4", up, LDO);
      end else if (a == 1) begin
        press(LGA); settle();
        check("R6 hw reset one pulse", n_rst - r0, 1);
        check("R6 hw reset rails stay", n_sysfall - f0, 0);
      end else begin
        press(LGA); settle();
        check("R5 no-op code no reset", n_rst - r0, 0);
        check("R5 no-op code rails stay", n_sysfall - f0, 0);
      end
    end
    cfg_restart_sel = 2'd1;

    // R6 gating on input valid
    cfg_long_act = 3'd1; cfg_rst_need_vin = 1'b1;
    r0 = n_rst;
    press(LGA); settle();
    check("R6 gated reset without vin", n_rst - r0, 0);
    vin_ok = 1'b1;
    r0 = n_rst;
    press(LGA); settle();
    check("R6 gated reset with vin", n_rst - r0, 1);
    vin_ok = 1'b0; cfg_rst_need_vin = 1'b0;
    settle();

    // R7 low-power pin turns reset into power cycle
    lp_n = 1'b0; r0 = n_rst;
    press(LGA); meas(off, up);
    check("R7 lp reset off time", off, CYC);
    check("R7 lp reset no pulse", n_rst - r0, 0);
    lp_n = 1'b1;

    // R10 host abort, late and early
    cfg_long_act = 3'd2;
    l0 = n_long; f0 = n_sysfall;
    press_abort(LGB, LGA + 2); settle();
    check("R10 late abort keeps rails", n_sysfall - f0, 0);
    check("R10 late abort long event", n_long - l0, 1);
    l0 = n_long; f0 = n_sysfall;
    press_abort(LGB, 3); settle();
    check("R10 early abort keeps rails", n_sysfall - f0, 0);
    check("R10 early abort long event", n_long - l0, 1);

    // R12 tick gating freezes press timing
    cfg_long_act = 3'd1; tick_en = 1'b0;
    s0 = n_short; l0 = n_long; r0 = n_rst;
    press(LGB + 10); settle();
    check("R12 no short without tick", n_short - s0, 0);
    check("R12 no long without tick", n_long - l0, 0);
    check("R12 no reset without tick", n_rst - r0, 0);
    tick_en = 1'b1;
    cfg_long_act = 3'd0;

    // R11 bus-silence watchdog
    @(posedge clk); #1 cfg_wd_en = 1'b1;
    repeat (3) @(posedge clk);
    wd_wait(k);
    check("R11 watchdog fire time", k, WD + 2);
    @(posedge clk); #1 vin_ok = 1'b0;
    repeat (3) @(posedge clk);
    r0 = n_rst;
    @(posedge clk); #1 vin_ok = 1'b1;
    repeat (2 * WD) @(posedge clk);
    check("R11 fires once until re-enabled", n_rst - r0, 0);
    #1 vin_ok = 1'b0; cfg_wd_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 cfg_wd_en = 1'b1;
    repeat (3) @(posedge clk);
    r0 = n_rst;
    #1 vin_ok = 1'b1;
    repeat (10) @(posedge clk);
    #1 host_txn = 1'b1;
    @(posedge clk); #1 host_txn = 1'b0;
    repeat (2 * WD) @(posedge clk);
    check("R11 transaction cancels window", n_rst - r0, 0);
    #1 vin_ok = 1'b0;
    repeat (3) @(posedge clk);
    r0 = n_rst;
    #1 vin_ok = 1'b1;
    repeat (2 * WD) @(posedge clk);
    check("R11 transaction disarms", n_rst - r0, 0);
    #1 vin_ok = 1'b0; cfg_wd_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 cfg_wd_en = 1'b1;
    repeat (3) @(posedge clk);
    wd_wait(k);
    check("R11 re-enable re-arms", k, WD + 2);
    #1 vin_ok = 1'b0;
    settle();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule